// File: doc/BRIEF.md
# SD card clock divider

This block derives the clock sent to an SD card from the host reference clock. Software programs one 32-bit control word through a simple write port. The word holds a one-hot power-of-two divisor code, a pass-through bit, a divide-by-1024 bit, a clock-enable bit and an automatic-stop bit. The block reads the word back unchanged, within the bits it implements. To pick a code, software rounds the requested ratio up to a power of two and shifts it right by two places.

The divided clock comes from a small state machine with four states. `S_STOP` holds the output low. `S_HIGH` and `S_LOW` each count out one half period. `S_PASS` forwards the reference clock. The named transitions are:

- **start**: `S_STOP` to `S_HIGH` or to `S_PASS`, when running is allowed.
- **fall**: `S_HIGH` to `S_LOW`, when the half-period count runs out.
- **rise**: `S_LOW` to `S_HIGH`.
- **park**: `S_LOW` to `S_STOP`, when running is no longer allowed.
- **reselect**: `S_LOW` to `S_PASS`.
- **leave**: `S_PASS` to `S_STOP`.

The block loads a new divisor only on the start and rise transitions, so a pulse in progress always finishes at its old width. The pass-through gate is retimed on the falling reference edge, so it opens and closes only while the reference clock is low.

When automatic stop is enabled and neither the command nor the data path reports activity, the clock parks low after it finishes its current period. It starts again as soon as either path becomes busy.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the readback is 0 and `card_clk` stays low with no rising edge.
- R2: Bits 0 to 10 and bit 16 of the control word read back exactly as last written. All other bits read 0.
- R3: When bits 10 and 16 are clear and the highest set bit of field [7:0] is i, the ratio is 4·2^i. The output is high for 2·2^i reference cycles and low for the same count. Lower set bits are ignored.
- R4: When bits [7:0], 10 and 16 are all clear, the ratio is 2: one reference cycle high, then one low.
- R5: Bit 10 set forwards the reference clock to `card_clk`, whatever the other divisor bits hold.
- R6: Bit 16 set (with bit 10 clear) selects ratio 1024, with 512 cycles high and 512 low, whatever field [7:0] holds.
- R7: Clearing the enable bit (bit 8) lets the current high pulse and the low phase that follows finish at full width. The output then stays low.
- R8: A divisor written during a high pulse leaves that pulse and the low phase after it at the old width. The next pulse uses the new width.
- R9: With bit 9 set and both `cmd_busy` and `dat_busy` low, the clock parks low. It runs again while either busy input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Host reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| cmd_busy | input | 1 | Command path active |
| dat_busy | input | 1 | Data path active |
| rd_data | output | 32 | Readback of the control word |
| card_clk | output | 1 | Clock to the card |

## Verification
The hardest case to reach from the ports is a divisor rewrite that lands inside a high pulse. Getting there requires timing the write against the output edge rather than against the reference clock.

The bench runs a monitor that records the width of every completed high and low run of `card_clk` and counts rising edges. Stimulus waits for a fresh rising edge and then writes a new code a few cycles later, while the old pulse is still high. It then checks that the old high and low widths appear once before the new width. The automatic stop is reached the same way, by toggling the busy inputs while the clock runs and checking that the edge count freezes and then resumes.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
    localparam int REG_W    = 32;
    localparam int CODE_W   = 8;
    localparam int POS_EN   = 8;
    localparam int POS_AUTO = 9;
    localparam int POS_DIV1 = 10;
    localparam int POS_SLOW = 16;
    localparam int HALF_W   = CODE_W + 2;

    typedef enum logic [1:0] {
        S_STOP = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2,
        S_PASS = 2'd3
    } clk_state_e;
endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
    import sdclk_pkg::*;
#(
    parameter bit EXT_DIV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [CODE_W-1:0] code,
    output logic              en,
    output logic              auto_stop,
    output logic              div1,
    output logic              slow
);
    localparam logic [REG_W-1:0] CODE_MASK = REG_W'((64'd1 << CODE_W) - 64'd1);
    localparam logic [REG_W-1:0] CTRL_MASK = (REG_W'(1) << POS_EN) |
                                             (REG_W'(1) << POS_AUTO) |
                                             (REG_W'(1) << POS_DIV1);
    localparam logic [REG_W-1:0] SLOW_MASK = EXT_DIV ? (REG_W'(1) << POS_SLOW) : '0;
    localparam logic [REG_W-1:0] KEEP_MASK = CODE_MASK | CTRL_MASK | SLOW_MASK;

    logic [REG_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else if (wr_en)
            word_q <= wr_data & KEEP_MASK;
    end

    assign rd_data   = word_q;
    assign code      = word_q[CODE_W-1:0];
    assign en        = word_q[POS_EN];
    assign auto_stop = word_q[POS_AUTO];
    assign div1      = word_q[POS_DIV1];
    assign slow      = word_q[POS_SLOW];

    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_data == ($past(wr_data) & KEEP_MASK)));
endmodule

// File: rtl/sdclk_ratio_dec.sv
module sdclk_ratio_dec
    import sdclk_pkg::*;
#(
    parameter bit EXT_DIV = 1'b1
) (
    input  logic [CODE_W-1:0] code,
    input  logic              div1,
    input  logic              slow,
    output logic              pass,
    output logic [HALF_W-1:0] half
);
    logic slow_sel;
    logic [HALF_W-1:0] field_half;

    generate
        if (EXT_DIV) begin : g_slow
            assign slow_sel = slow;
        end else begin : g_no_slow
            logic unused_slow;
            assign unused_slow = slow;
            assign slow_sel    = 1'b0;
        end
    endgenerate

    // Highest set bit of the code field wins; an empty field means ratio 2.
    always_comb begin
        field_half = HALF_W'(1);
        for (int i = 0; i < CODE_W; i++) begin
            if (code[i])
                field_half = HALF_W'(2) << i;
        end
    end

    always_comb begin
        pass = div1;
        if (slow_sel)
            half = HALF_W'(1) << (CODE_W + 1);
        else
            half = field_half;
    end
endmodule

// File: rtl/sdclk_fsm.sv
module sdclk_fsm
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_ok,
    input  logic              sel_pass,
    input  logic [HALF_W-1:0] sel_half,
    output logic              card_clk
);
    clk_state_e        state_q, state_d;
    logic [HALF_W-1:0] cnt_q, cnt_d;
    logic [HALF_W-1:0] half_q, half_d;
    logic              div_q;
    logic              pass_en_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        half_d  = half_q;
        unique case (state_q)
            S_STOP: begin
                if (run_ok) begin
                    if (sel_pass) begin
                        state_d = S_PASS;
                    end else begin
                        state_d = S_HIGH;
                        half_d  = sel_half;
                        cnt_d   = sel_half - HALF_W'(1);
                    end
                end
            end
            S_HIGH: begin
                if (cnt_q == '0) begin
                    state_d = S_LOW;
                    cnt_d   = half_q - HALF_W'(1);
                end else begin
                    cnt_d = cnt_q - HALF_W'(1);
                end
            end
            S_LOW: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - HALF_W'(1);
                end else if (!run_ok) begin
                    state_d = S_STOP;
                end else if (sel_pass) begin
                    state_d = S_PASS;
                end else begin
                    state_d = S_HIGH;
                    half_d  = sel_half;
                    cnt_d   = sel_half - HALF_W'(1);
                end
            end
            S_PASS: begin
                if (!run_ok || !sel_pass)
                    state_d = S_STOP;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_STOP;
            cnt_q   <= '0;
            half_q  <= HALF_W'(1);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_d;
        end
    end

    // Outputs: registered divided level, pass gate retimed on the falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= 1'b0;
        else
            div_q <= (state_d == S_HIGH);
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            pass_en_q <= 1'b0;
        else
            pass_en_q <= (state_q == S_PASS);
    end

    assign card_clk = div_q | (clk & pass_en_q);

    p_stop_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP && $past(state_q) != S_STOP) |->
        ($past(state_q) == S_LOW || $past(state_q) == S_PASS));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STOP && !run_ok) |=> (state_q == S_STOP));

    p_half_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOW) |-> $stable(half_q));

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HIGH || state_q == S_LOW) |-> (cnt_q < half_q));

    p_pass_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PASS) |-> $past(sel_pass));
endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter bit EXT_DIV = 1'b1
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              cmd_busy,
    input  logic              dat_busy,
    output logic [REG_W-1:0]  rd_data,
    output logic              card_clk
);
    logic [CODE_W-1:0] code;
    logic              en, auto_stop, div1, slow;
    logic              sel_pass;
    logic [HALF_W-1:0] sel_half;
    logic              run_ok;

    sdclk_ctrl_reg #(.EXT_DIV(EXT_DIV)) i_reg (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .code      (code),
        .en        (en),
        .auto_stop (auto_stop),
        .div1      (div1),
        .slow      (slow)
    );

    sdclk_ratio_dec #(.EXT_DIV(EXT_DIV)) i_dec (
        .code (code),
        .div1 (div1),
        .slow (slow),
        .pass (sel_pass),
        .half (sel_half)
    );

    assign run_ok = en & (~auto_stop | cmd_busy | dat_busy);

    sdclk_fsm i_fsm (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .run_ok   (run_ok),
        .sel_pass (sel_pass),
        .sel_half (sel_half),
        .card_clk (card_clk)
    );
endmodule

// File: tb/test_sdclk_gen.sv
`timescale 1ns/1ps
module test_sdclk_gen;
    localparam logic [31:0] B_EN   = 32'h0000_0100;
    localparam logic [31:0] B_AUTO = 32'h0000_0200;
    localparam logic [31:0] B_DIV1 = 32'h0000_0400;
    localparam logic [31:0] B_SLOW = 32'h0001_0000;
    localparam logic [31:0] KEEP   = 32'h0001_07FF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        cmd_busy = 1'b0;
    logic        dat_busy = 1'b0;
    logic [31:0] rd_data;
    logic        card_clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // pulse monitor
    int  n_rise = 0;
    int  run_len = 0;
    int  last_hi = 0;
    int  last_lo = 0;
    logic prev_v = 1'b0;

    always #2.5 clk = ~clk;

    sdclk_gen i_sdclk_gen (
        .clk_ref  (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .cmd_busy (cmd_busy),
        .dat_busy (dat_busy),
        .rd_data  (rd_data),
        .card_clk (card_clk)
    );

    always begin
        @(posedge clk);
        #1.25;
        if (card_clk !== prev_v) begin
            if (card_clk === 1'b1) begin
                last_lo = run_len;
                n_rise++;
            end else begin
                last_hi = run_len;
            end
            run_len = 0;
        end
        run_len++;
        prev_v = card_clk;
    end

    function automatic int exp_half(input logic [31:0] v);
        int h;
        h = 1;
        if (v[10]) return 0;
        if (v[16]) return 512;
        for (int i = 0; i < 8; i++) if (v[i]) h = 2 << i;
        return h;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rises(input int k);
        int tgt;
        int lim;
        tgt = n_rise + k;
        lim = 0;
        while (n_rise < tgt && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
    endtask

    task automatic cfg(input logic [31:0] v);
        wr(v & ~B_EN);
        repeat (1100) @(negedge clk);
        wr(v | B_EN);
        wait_rises(3);
    endtask

    initial begin
        int base;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // R1 reset state
        check("R1 readback", int'(rd_data), 0);
        check("R1 card_clk", int'(card_clk), 0);
        check("R1 rises", n_rise, 0);

        // R2 readback of random words
        for (int k = 0; k < 8; k++) begin
            logic [31:0] v;
            v = $urandom & ~B_EN;
            wr(v);
            check("R2 readback", int'(rd_data), int'(v & KEEP));
        end

        // R4 ratio 2
        cfg(32'h0);
        check("R4 high", last_hi, 1);
        check("R4 low", last_lo, 1);

        // R3 / R6 random codes with noise below the top bit
        for (int k = 0; k < 10; k++) begin
            int sel;
            int h;
            logic [31:0] v;
            sel = $urandom % 10;
            if (sel < 8)
                v = (32'd1 << sel) | ($urandom & ((32'd1 << sel) - 32'd1));
            else if (sel == 8)
                v = 32'h0;
            else
                v = B_SLOW | ($urandom & 32'hFF);
            cfg(v);
            h = exp_half(v);
            check("R3 high", last_hi, h);
            check("R3 low", last_lo, h);
        end

        // R6 divide by 1024 overrides the field
        cfg(B_SLOW | 32'h80);
        check("R6 high", last_hi, 512);
        check("R6 low", last_lo, 512);

        // R5 pass-through overrides both other selects
        wr(B_DIV1 | B_SLOW | 32'h81 | B_EN);
        repeat (1100) @(negedge clk);
        check("R5 steady high phase", int'(prev_v), 1);
        check("R5 run length", (run_len >= 20) ? 1 : 0, 1);
        @(negedge clk);
        #1.25;
        check("R5 low phase", int'(card_clk), 0);

        // R8 change during a high pulse
        cfg(32'h02);
        check("R8 setup high", last_hi, 4);
        wait_rises(1);
        wr(32'h01 | B_EN);
        wait_rises(1);
        check("R8 old high", last_hi, 4);
        check("R8 old low", last_lo, 4);
        wait_rises(1);
        check("R8 new high", last_hi, 2);
        check("R8 new low", last_lo, 2);

        // R7 disable during a high pulse
        cfg(32'h02);
        wait_rises(1);
        base = n_rise;
        wr(32'h02);
        repeat (60) @(negedge clk);
        check("R7 last high", last_hi, 4);
        check("R7 no new rise", n_rise - base, 0);
        check("R7 held low", int'(prev_v), 0);

        // R9 automatic stop
        wr(B_EN | B_AUTO | 32'h01);
        repeat (20) @(negedge clk);
        base = n_rise;
        repeat (40) @(negedge clk);
        check("R9 idle no rise", n_rise - base, 0);
        check("R9 idle low", int'(card_clk), 0);
        cmd_busy = 1'b1;
        wait_rises(3);
        check("R9 cmd high", last_hi, 2);
        check("R9 cmd low", last_lo, 2);
        cmd_busy = 1'b0;
        dat_busy = 1'b1;
        base = n_rise;
        repeat (40) @(negedge clk);
        check("R9 dat rises", n_rise - base, 10);
        dat_busy = 1'b0;
        repeat (20) @(negedge clk);
        base = n_rise;
        repeat (40) @(negedge clk);
        check("R9 parked again", n_rise - base, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule